// File: doc/BRIEF.md
# Fixed-Priority Pending-Latch Interrupt Controller

This block collects interrupt events from eleven sources: the bus-reset detector, two periodic timers, five USB endpoints, the DAC comparator, the general-purpose port and the two-wire serial unit. Each source has its own pending flop. An event pulse sets that flop, and the flop stays set until the controller services that source or the block is reset. Masking a source does not discard its pending state. Two byte-wide enable registers decide which sources may raise a request. One register covers the system sources and the other covers the endpoints. A CPU-side global enable gates all requests.

When the CPU reports the end of an instruction and at least one request is active, the controller services the lowest-numbered active source in a single clock edge. At that edge it clears the global enable, clears that source's pending flop, and issues a one-cycle vector-call strobe with the source's index. The CPU sets the global enable again with an enable-interrupts pulse. Nested servicing therefore needs no state inside the controller.

Top module: `irq_prio_ctrl`

## Requirements
- R1: Each source i (index 0 to 10) has a pending flop. An event pulse on `src_event[i]` sets it at the next edge. The flop stays set until source i is serviced or reset is applied. The setting and holding happen whatever the enable values are.
- R2: A pending source i can be serviced only while its enable bit is 1 and `gie` is 1. With `gie` at 0, `vec_call` stays 0.
- R3: A write (`bus_we`=1) to address 0x20 sets the enables of the system sources. Bit 0 controls source 0 (bus reset), bit 1 source 1 (short timer), bit 2 source 2 (long timer), bit 4 source 8 (DAC), bit 5 source 9 (general-purpose port) and bit 6 source 10 (serial unit). Bits 3 and 7 have no effect.
- R4: A write to address 0x21 sets the endpoint enables. Bits 0 to 4 control sources 3 to 7 in order, and bits 5 to 7 have no effect. A write to any other address changes no enable.
- R5: Reset (`rst_n`=0, asynchronous) clears both enable registers, `gie` and every pending flop. Afterwards `vec_call`=0, `vec_idx`=0 and `irq_pending`=0.
- R6: Servicing happens only on an edge where `instr_done` is 1.
- R7: When a source is serviced, the same edge does three things. It sets `gie` to 0, clears that source's pending flop, and raises `vec_call` for exactly one cycle. `vec_idx` takes the source index at that edge and holds it until the next service.
- R8: When several requests are active, the lowest source index is serviced. The order is 0 bus reset, 1 short timer, 2 long timer, 3 to 7 endpoints, 8 DAC, 9 general-purpose port and 10 serial unit.
- R9: `irq_pending` is 1 exactly while at least one pending flop is set. It falls at the edge where servicing clears the last one.
- R10: If an event arrives on the same edge that services its source, the source stays pending.
- R11: An `ei` pulse sets `gie` at the next edge. If servicing happens on that same edge, `gie` becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_event | input | 11 | One event pulse per source, indexed by priority |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register write address |
| bus_wdata | input | 8 | Register write data |
| instr_done | input | 1 | Current instruction completes this cycle |
| ei | input | 1 | Set the global enable |
| gie | output | 1 | CPU global interrupt enable |
| irq_pending | output | 1 | At least one source is pending |
| vec_call | output | 1 | One-cycle vector-call strobe |
| vec_idx | output | 4 | Index of the serviced source |

## Verification
Every result shows one clock edge after the cycle that causes it. A pending flop, and so `irq_pending`, rises one edge after the event. `vec_call`, `vec_idx` and the cleared `gie` appear one edge after the cycle where `instr_done` met an active request. A register write or an `ei` pulse only changes decisions taken from the following cycle on. The bench drives all inputs just after a falling edge. It advances its model by one step per cycle and compares the outputs at the next falling edge, so each expected value is sampled exactly one rising edge after its stimulus.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  localparam int NUM_SRC = 11;
  localparam int VEC_W   = $clog2(NUM_SRC);
  localparam int REG_W   = 8;

  localparam int SRC_BUSRST = 0;
  localparam int SRC_T128   = 1;
  localparam int SRC_T1024  = 2;
  localparam int SRC_EP0    = 3;
  localparam int NUM_EP     = 5;
  localparam int SRC_DAC    = 8;
  localparam int SRC_GPIO   = 9;
  localparam int SRC_SER    = 10;

  localparam logic [REG_W-1:0] SYS_IMPL_MASK = 8'h77;
  localparam logic [REG_W-1:0] EP_IMPL_MASK  = 8'h1F;

  typedef logic [NUM_SRC-1:0] src_vec_t;

  function automatic src_vec_t lowest_onehot(input src_vec_t v);
    return v & (~v + src_vec_t'(1));
  endfunction

  function automatic logic [VEC_W-1:0] onehot_to_idx(input src_vec_t oh);
    logic [VEC_W-1:0] idx;
    idx = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (oh[i]) idx = idx | VEC_W'(i);
    end
    return idx;
  endfunction

  function automatic src_vec_t map_enables(input logic [REG_W-1:0] sys_r,
                                           input logic [REG_W-1:0] ep_r);
    src_vec_t m;
    m = '0;
    m[SRC_BUSRST] = sys_r[0];
    m[SRC_T128]   = sys_r[1];
    m[SRC_T1024]  = sys_r[2];
    for (int k = 0; k < NUM_EP; k++) m[SRC_EP0 + k] = ep_r[k];
    m[SRC_DAC]    = sys_r[4];
    m[SRC_GPIO]   = sys_r[5];
    m[SRC_SER]    = sys_r[6];
    return m;
  endfunction
endpackage

// File: rtl/irq_en_regs.sv
module irq_en_regs
  import irq_prio_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] SYS_ADDR = 8'h20,
  parameter logic [ADDR_W-1:0] EP_ADDR  = 8'h21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output src_vec_t          en_vec
);
  logic [REG_W-1:0] sys_q, ep_q;
  logic sys_hit, ep_hit;

  assign sys_hit = bus_we && (bus_addr == SYS_ADDR);
  assign ep_hit  = bus_we && (bus_addr == EP_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sys_q <= '0;
      ep_q  <= '0;
    end else begin
      if (sys_hit) sys_q <= bus_wdata & SYS_IMPL_MASK;
      if (ep_hit)  ep_q  <= bus_wdata & EP_IMPL_MASK;
    end
  end

  assign en_vec = map_enables(sys_q, ep_q);
endmodule

// File: rtl/irq_pend_bank.sv
module irq_pend_bank
  import irq_prio_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  src_vec_t set_vec,
  input  src_vec_t clr_vec,
  output src_vec_t pend_q
);
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_flop
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          pend_q[i] <= 1'b0;
      else if (set_vec[i]) pend_q[i] <= 1'b1;
      else if (clr_vec[i]) pend_q[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
  import irq_prio_pkg::*;
(
  input  src_vec_t         req_vec,
  output logic             any_req,
  output src_vec_t         win_onehot,
  output logic [VEC_W-1:0] win_idx
);
  assign any_req    = |req_vec;
  assign win_onehot = lowest_onehot(req_vec);
  assign win_idx    = onehot_to_idx(win_onehot);
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] SYS_ADDR = 8'h20,
  parameter logic [ADDR_W-1:0] EP_ADDR  = 8'h21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [10:0]       src_event,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              instr_done,
  input  logic              ei,
  output logic              gie,
  output logic              irq_pending,
  output logic              vec_call,
  output logic [3:0]        vec_idx
);
  src_vec_t en_vec, pend_q, req_vec, win_onehot, ack_onehot;
  logic any_req, ack_fire;
  logic [VEC_W-1:0] win_idx;

  irq_en_regs #(.ADDR_W(ADDR_W), .SYS_ADDR(SYS_ADDR), .EP_ADDR(EP_ADDR)) u_en (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .en_vec(en_vec)
  );

  assign req_vec = pend_q & en_vec & {NUM_SRC{gie}};

  irq_prio_pick u_pick (
    .req_vec(req_vec), .any_req(any_req),
    .win_onehot(win_onehot), .win_idx(win_idx)
  );

  assign ack_fire   = instr_done && any_req;
  assign ack_onehot = ack_fire ? win_onehot : '0;

  irq_pend_bank u_pend (
    .clk(clk), .rst_n(rst_n), .set_vec(src_event),
    .clr_vec(ack_onehot), .pend_q(pend_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gie      <= 1'b0;
      vec_call <= 1'b0;
      vec_idx  <= '0;
    end else begin
      vec_call <= ack_fire;
      if (ack_fire) begin
        gie     <= 1'b0;
        vec_idx <= win_idx;
      end else if (ei) begin
        gie <= 1'b1;
      end
    end
  end

  assign irq_pending = |pend_q;
endmodule

// File: rtl/irq_prio_chk.sv
module irq_prio_chk
  import irq_prio_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic [10:0] src_event,
  input logic        instr_done,
  input logic        gie,
  input logic        vec_call,
  input src_vec_t    pend_q,
  input src_vec_t    req_vec,
  input logic        ack_fire,
  input src_vec_t    ack_onehot
);
  AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (|src_event) |=> ((pend_q & $past(src_event)) == $past(src_event))); // R1
  AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack_fire && src_event == '0) |=> $stable(pend_q)); // R1
  AST_ACK_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
    vec_call |-> $past(gie)); // R2
  AST_ACK_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    vec_call |-> $past(instr_done)); // R6
  AST_GIE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    vec_call |-> !gie); // R7
  AST_CALL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    vec_call |=> !vec_call); // R7
  AST_SERVICED_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    ack_fire |=> ((pend_q & $past(ack_onehot & ~src_event)) == '0)); // R7
  AST_SINGLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ack_onehot)); // R8
  AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ack_fire |-> ((req_vec & (ack_onehot - src_vec_t'(1))) == '0)); // R8
  AST_EVENT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_fire && ((ack_onehot & src_event) != '0)) |=> ((pend_q & $past(ack_onehot)) != '0)); // R10
endmodule

bind irq_prio_ctrl irq_prio_chk u_chk (
  .clk(clk), .rst_n(rst_n), .src_event(src_event), .instr_done(instr_done),
  .gie(gie), .vec_call(vec_call), .pend_q(pend_q), .req_vec(req_vec),
  .ack_fire(ack_fire), .ack_onehot(ack_onehot)
);

// File: tb/irq_prio_ctrl_bench.sv
module irq_prio_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [10:0] src_event = '0;
  logic bus_we = 1'b0;
  logic [7:0] bus_addr = '0, bus_wdata = '0;
  logic instr_done = 1'b0, ei = 1'b0;
  logic gie, irq_pending, vec_call;
  logic [3:0] vec_idx;

  int checks = 0, errors = 0;
  bit finished = 0;

  logic [10:0] m_pend, m_en;
  logic m_gie, m_call;
  logic [3:0] m_idx;

  always #5 clk = ~clk;

  irq_prio_ctrl u_irq_prio_ctrl (
    .clk(clk), .rst_n(rst_n), .src_event(src_event), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .instr_done(instr_done),
    .ei(ei), .gie(gie), .irq_pending(irq_pending), .vec_call(vec_call),
    .vec_idx(vec_idx)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int pick(input logic [10:0] r);
    int s = -1;
    for (int i = 10; i >= 0; i--) if (r[i]) s = i;
    return s;
  endfunction

  function automatic logic [10:0] sys_map(input logic [7:0] d, input logic [10:0] old);
    logic [10:0] n = old;
    n[0] = d[0]; n[1] = d[1]; n[2] = d[2];
    n[8] = d[4]; n[9] = d[5]; n[10] = d[6];
    return n;
  endfunction

  function automatic logic [10:0] ep_map(input logic [7:0] d, input logic [10:0] old);
    logic [10:0] n = old;
    for (int k = 0; k < 5; k++) n[3+k] = d[k];
    return n;
  endfunction

  task automatic model_reset();
    m_pend = '0; m_en = '0; m_gie = 0; m_call = 0; m_idx = '0;
  endtask

  task automatic compare();
    check("R7", "vec_call", int'(vec_call), int'(m_call));
    check("R8", "vec_idx", int'(vec_idx), int'(m_idx));
    check("R11", "gie", int'(gie), int'(m_gie));
    check("R9", "irq_pending", int'(irq_pending), int'(|m_pend));
  endtask

  // Called at a negedge; drives one cycle, steps the model, compares at next negedge.
  task automatic cyc(input logic [10:0] ev, input logic we, input logic [7:0] a,
                     input logic [7:0] d, input logic done, input logic e);
    logic [10:0] req;
    int s;
    src_event = ev; bus_we = we; bus_addr = a; bus_wdata = d;
    instr_done = done; ei = e;
    req = m_pend & m_en & {11{m_gie}};
    s = pick(req);
    m_call = done && (s >= 0);
    if (m_call) begin
      m_idx = 4'(s);
      m_pend[s] = 1'b0;
      m_gie = 1'b0;
    end else if (e) m_gie = 1'b1;
    m_pend = m_pend | ev;
    if (we && a == 8'h20) m_en = sys_map(d, m_en);
    if (we && a == 8'h21) m_en = ep_map(d, m_en);
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic idle(); cyc('0, 0, 8'h00, 8'h00, 0, 0); endtask

  task automatic do_reset();
    rst_n = 1'b0;
    src_event = '0; bus_we = 0; instr_done = 0; ei = 0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    int cnt = 0;
    while (!finished) begin
      @(posedge clk);
      cnt++;
      if (cnt > 150000) begin
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", cnt, 150000);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd2024));
    do_reset();
    // R5: reset state
    check("R5", "vec_call", int'(vec_call), 0);
    check("R5", "vec_idx", int'(vec_idx), 0);
    check("R5", "irq_pending", int'(irq_pending), 0);
    check("R5", "gie", int'(gie), 0);

    // R1/R2: masked source latches but is not serviced
    cyc(11'h200, 0, 0, 0, 0, 1);
    check("R1", "pending after masked event", int'(irq_pending), 1);
    cyc('0, 0, 0, 0, 1, 0);
    check("R2", "no call while masked", int'(vec_call), 0);
    repeat (3) idle();
    check("R1", "pending survives mask", int'(irq_pending), 1);

    // R3/R6/R7/R9: enable general-purpose port (bit 5), service it
    cyc('0, 1, 8'h20, 8'h20, 0, 0);
    idle();
    check("R6", "no call without instr_done", int'(vec_call), 0);
    cyc('0, 0, 0, 0, 1, 0);
    check("R3", "call for bit5 source", int'(vec_call), 1);
    check("R7", "vector index", int'(vec_idx), 9);
    check("R7", "gie cleared", int'(gie), 0);
    check("R9", "pending dropped", int'(irq_pending), 0);
    idle();
    check("R7", "strobe one cycle", int'(vec_call), 0);

    // R3/R4: reserved bits and other addresses
    cyc(11'h001, 1, 8'h20, 8'h88, 0, 1);
    cyc('0, 0, 0, 0, 1, 0);
    check("R3", "reserved sys bits", int'(vec_call), 0);
    cyc(11'h008, 1, 8'h21, 8'hE0, 0, 0);
    cyc('0, 0, 0, 0, 1, 0);
    check("R4", "reserved ep bits", int'(vec_call), 0);
    cyc('0, 1, 8'h22, 8'hFF, 0, 0);
    cyc('0, 0, 0, 0, 1, 0);
    check("R4", "other address ignored", int'(vec_call), 0);

    // R8: priority 0, then 3, then 10
    cyc(11'h400, 1, 8'h20, 8'h77, 0, 0);
    cyc('0, 1, 8'h21, 8'h1F, 0, 0);
    cyc('0, 0, 0, 0, 1, 0);
    check("R8", "lowest first", int'(vec_idx), 0);
    cyc('0, 0, 0, 0, 0, 1);
    cyc('0, 0, 0, 0, 1, 0);
    check("R8", "second", int'(vec_idx), 3);
    cyc('0, 0, 0, 0, 0, 1);
    cyc('0, 0, 0, 0, 1, 0);
    check("R8", "third", int'(vec_idx), 10);

    // R10: event on the serviced source during its clear
    cyc(11'h002, 0, 0, 0, 0, 1);
    cyc(11'h002, 0, 0, 0, 1, 0);
    check("R10", "serviced", int'(vec_idx), 1);
    check("R10", "still pending", int'(irq_pending), 1);
    // R11: ei on the service edge loses
    cyc('0, 0, 0, 0, 0, 1);
    cyc('0, 0, 0, 0, 1, 1);
    check("R11", "gie low after service with ei", int'(gie), 0);
    check("R10", "kept event serviced", int'(vec_idx), 1);

    // R5: reset clears enables
    do_reset();
    cyc(11'h001, 0, 0, 0, 0, 1);
    cyc('0, 0, 0, 0, 1, 0);
    check("R5", "enables cleared", int'(vec_call), 0);

    // random phase
    for (int n = 0; n < 4000; n++) begin
      logic [10:0] ev;
      logic we, dn, e;
      logic [7:0] a, d;
      for (int b = 0; b < 11; b++) ev[b] = ($urandom % 10) == 0;
      we = ($urandom % 8) == 0;
      case ($urandom % 3)
        0: a = 8'h20;
        1: a = 8'h21;
        default: a = 8'($urandom);
      endcase
      d = 8'($urandom);
      dn = $urandom % 2;
      e = ($urandom % 4) == 0;
      cyc(ev, we, a, d, dn, e);
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule